// File: doc/BRIEF.md
# Seeded Page Data Scrambler

This block sits on the byte path between the host-side interface and the page cache. It whitens each data byte before the byte is programmed and removes the whitening when the byte is read back. The mask is one byte of keystream from a 16-bit Fibonacci shift register, XORed with the data in the same cycle. The register is reloaded from a 16-entry seed table at the start of every chunk of the page. The entry is chosen from the page address plus the chunk index, so any column of any page always meets the same keystream byte.

The host first presents a page and a column with a load strobe. The block reseeds for the chunk that holds that column. It then steps forward one byte per cycle until it reaches the column's offset inside the chunk, and holds a busy flag while it does so. After that, every write beat (data input) or read beat (data output) uses one keystream byte and moves to the next column. A bypass input lets raw test patterns through while the position keeps moving.

Top module: `page_scrambler`

## Requirements
- R1: After reset the position is page 0, column 0, `seek_busy` is low, and the mask is the high byte of seed entry 0 (0x44).
- R2: Each beat steps the register 8 times. One step shifts left and puts the XOR of bits 15, 13, 12 and 10 into bit 0. The mask byte is bits 15..8 of the current state.
- R3: With bypass low, `dout` equals `din` XOR the mask in the same cycle.
- R4: A column range scrambled by write beats is restored by read beats after the same page and column are loaded again.
- R5: When a beat moves the column onto a chunk start (a multiple of 16), the register is loaded with table entry (page + chunk) mod 16 instead of stepping.
- R6: Table entry i is (i*0x1111) XOR 0x4444. An entry of zero is replaced by 0xACE1, so the state is never zero.
- R7: A beat on the last column (63) wraps to column 0 and reseeds from chunk 0 of the same page.
- R8: A load reseeds for the chunk that holds `col_addr`. `seek_busy` is then high for exactly (col_addr mod 16) cycles, after which the mask matches that column.
- R9: Beats in a load cycle or while `seek_busy` is high are ignored.
- R10: With bypass high, `dout` equals `din`, and beats still advance the keystream.
- R11: In cycles with no beat and no load, the mask holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| page_addr | input | PAGE_W | Page address, taken on a load |
| col_addr | input | COL_W | Column address, taken on a load |
| addr_load | input | 1 | Load the page and column, then reseed and seek |
| wr_beat | input | 1 | Data-input beat |
| rd_beat | input | 1 | Data-output beat |
| bypass | input | 1 | Pass data through unmasked |
| din | input | 8 | Data byte in |
| dout | output | 8 | Masked (or bypassed) data byte out |
| seek_busy | output | 1 | High while the block steps toward a loaded offset |

## Verification
The bench targets the chunk edges, where a design that steps instead of reseeding would decode every later chunk wrongly. It also targets the wrap from column 63, which a faulty design would carry into the next page's seed instead of returning to chunk 0. A load into the middle of a chunk checks the exact busy length and the mask that follows it: an off-by-one seek shifts the whole keystream by one byte. The bench also covers beats issued during a seek or a load cycle, the zero table entry that must be replaced, and bypass, which must still advance the keystream so that decoding stays aligned afterwards.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int          SEL_W        = 4;
  localparam int          SEED_N       = 1 << SEL_W;
  localparam logic [15:0] FB_TAPS      = 16'hB400;
  localparam logic [15:0] SEED_DEFAULT = 16'hACE1;

  // single shift: XOR of tapped bits enters bit 0
  function automatic logic [15:0] lfsr_bit(input logic [15:0] s);
    return {s[14:0], ^(s & FB_TAPS)};
  endfunction

  // eight shifts per data beat
  function automatic logic [15:0] lfsr_byte(input logic [15:0] s);
    logic [15:0] t;
    t = s;
    for (int k = 0; k < 8; k++) t = lfsr_bit(t);
    return t;
  endfunction

  function automatic logic [15:0] seed_of(input logic [SEL_W-1:0] i);
    logic [15:0] v;
    v = (16'(i) * 16'h1111) ^ 16'h4444;
    return (v == 16'h0) ? SEED_DEFAULT : v;
  endfunction
endpackage

// File: rtl/scr_seed_rom.sv
module scr_seed_rom
  import scr_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  output logic [15:0]      seed
);
  logic [15:0] table_q [SEED_N];

  for (genvar g = 0; g < SEED_N; g++) begin : g_ent
    assign table_q[g] = seed_of(SEL_W'(g));
  end

  assign seed = table_q[sel];
endmodule

// File: rtl/scr_lfsr.sv
module scr_lfsr
  import scr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reseed,
  input  logic        adv,
  input  logic [15:0] seed,
  output logic [7:0]  key
);
  logic [15:0] state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state <= seed_of('0);
    else if (reseed) state <= seed;
    else if (adv)    state <= lfsr_byte(state);
  end

  assign key = state[15:8];

  // R6
  state_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state != 16'h0);
  // R5
  reseed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reseed |=> state == $past(seed));
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reseed && !adv) |=> $stable(state));
endmodule

// File: rtl/scr_pos.sv
module scr_pos
  import scr_pkg::*;
#(
  parameter int COL_W  = 6,
  parameter int OFF_W  = 4,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] page_addr,
  input  logic [COL_W-1:0]  col_addr,
  input  logic              addr_load,
  input  logic              beat,
  output logic              reseed,
  output logic              adv,
  output logic [SEL_W-1:0]  sel,
  output logic              busy
);
  localparam int CHUNK_W = COL_W - OFF_W;

  logic [PAGE_W-1:0] page;
  logic [COL_W-1:0]  col;
  logic [OFF_W-1:0]  seek;
  logic [COL_W-1:0]  col_nx;
  logic              beat_ok;
  logic              boundary;

  assign busy     = (seek != '0);
  assign beat_ok  = beat && !busy && !addr_load;
  assign col_nx   = col + 1'b1;
  assign boundary = (col_nx[OFF_W-1:0] == '0);
  assign reseed   = addr_load || (beat_ok && boundary);
  assign adv      = !addr_load && (busy || (beat_ok && !boundary));

  always_comb begin
    if (addr_load)
      sel = SEL_W'((page_addr + PAGE_W'(col_addr[COL_W-1:OFF_W])) % SEED_N);
    else
      sel = SEL_W'((page + PAGE_W'(col_nx[COL_W-1:OFF_W])) % SEED_N);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page <= '0;
      col  <= '0;
      seek <= '0;
    end else if (addr_load) begin
      page <= page_addr;
      col  <= col_addr;
      seek <= col_addr[OFF_W-1:0];
    end else if (busy) begin
      seek <= seek - 1'b1;
    end else if (beat_ok) begin
      col <= col_nx;
    end
  end

  // R9
  busy_ignores_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !addr_load) |=> col == $past(col));
  // R8
  seek_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !addr_load) |=> seek == OFF_W'($past(seek) - 1'b1));
  // R7
  col_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ok && col == '1) |=> col == '0);
  // R5
  step_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reseed && adv));
  // unused in the checks above only when CHUNK_W is zero
  initial begin
    chunk_w_chk: assert (CHUNK_W > 0);
  end
endmodule

// File: rtl/page_scrambler.sv
module page_scrambler
  import scr_pkg::*;
#(
  parameter int COL_W  = 6,
  parameter int OFF_W  = 4,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] page_addr,
  input  logic [COL_W-1:0]  col_addr,
  input  logic              addr_load,
  input  logic              wr_beat,
  input  logic              rd_beat,
  input  logic              bypass,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              seek_busy
);
  logic             reseed;
  logic             adv;
  logic [SEL_W-1:0] sel;
  logic [15:0]      seed;
  logic [7:0]       key;

  scr_pos #(.COL_W(COL_W), .OFF_W(OFF_W), .PAGE_W(PAGE_W)) pos_i (
    .clk(clk), .rst_n(rst_n), .page_addr(page_addr), .col_addr(col_addr),
    .addr_load(addr_load), .beat(wr_beat || rd_beat), .reseed(reseed),
    .adv(adv), .sel(sel), .busy(seek_busy)
  );

  scr_seed_rom rom_i (.sel(sel), .seed(seed));

  scr_lfsr lfsr_i (
    .clk(clk), .rst_n(rst_n), .reseed(reseed), .adv(adv),
    .seed(seed), .key(key)
  );

  assign dout = bypass ? din : (din ^ key);

  // R10
  bypass_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> dout == din);
endmodule

// File: tb/page_scrambler_tb_top.sv
module page_scrambler_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] page_addr = '0;
  logic [5:0] col_addr = '0;
  logic       addr_load = 1'b0;
  logic       wr_beat = 1'b0;
  logic       rd_beat = 1'b0;
  logic       bypass = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       seek_busy;

  always #5 clk = ~clk;

  page_scrambler dut_i (
    .clk(clk), .rst_n(rst_n), .page_addr(page_addr), .col_addr(col_addr),
    .addr_load(addr_load), .wr_beat(wr_beat), .rd_beat(rd_beat),
    .bypass(bypass), .din(din), .dout(dout), .seek_busy(seek_busy)
  );

  int errors = 0;
  int checks = 0;
  string tag = "R1";

  // reference model state
  int ms, mcol, mpage, mseek;

  function automatic int ref_step(int s);
    int v = s;
    for (int n = 0; n < 8; n++) begin
      int fb = ((v >> 15) ^ (v >> 13) ^ (v >> 12) ^ (v >> 10)) & 1;
      v = ((v << 1) | fb) & 16'hFFFF;
    end
    return v;
  endfunction

  function automatic int ref_seed(int i);
    int v = ((i * 4369) & 16'hFFFF) ^ 16'h4444;
    if (v == 0) v = 16'hACE1;
    return v;
  endfunction

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // compare this cycle, then advance the model at the edge
  task automatic tick();
    int exp_out;
    #1;
    exp_out = bypass ? int'(din) : (int'(din) ^ ((ms >> 8) & 8'hFF));
    chk(int'(dout), exp_out, "dout");
    chk(int'(seek_busy), int'(mseek != 0), "seek_busy");
    @(posedge clk);
    if (addr_load) begin
      mpage = int'(page_addr); mcol = int'(col_addr); mseek = mcol % 16;
      ms = ref_seed((mpage + mcol / 16) % 16);
    end else if (mseek != 0) begin
      ms = ref_step(ms); mseek--;
    end else if (wr_beat || rd_beat) begin
      mcol = (mcol + 1) % 64;
      if (mcol % 16 == 0) ms = ref_seed((mpage + mcol / 16) % 16);
      else ms = ref_step(ms);
    end
    @(negedge clk);
  endtask

  task automatic do_load(input int pg, input int cl);
    page_addr = 8'(pg); col_addr = 6'(cl); addr_load = 1'b1;
    tick();
    addr_load = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    byte unsigned orig[$];
    byte unsigned scr[$];
    int busy_n;
    ms = ref_seed(0); mcol = 0; mpage = 0; mseek = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset keystream is high byte of entry 0
    tag = "R1"; din = 8'h00; #1;
    chk(int'(dout), 8'h44, "reset mask");
    chk(int'(seek_busy), 0, "reset busy");
    tick();

    // R2 R3 R5 R7: write beats across chunks and past the wrap
    tag = "R5";
    do_load(3, 0);
    for (int i = 0; i < 70; i++) begin
      tag = (i >= 63) ? "R7" : ((i % 16 == 15) ? "R5" : "R2");
      din = 8'((i * 7 + 1) & 8'hFF); wr_beat = 1'b1;
      if (i < 64) begin
        #1; orig.push_back(din); scr.push_back(dout);
      end
      tick();
    end
    wr_beat = 1'b0;

    // R4: read back restores the written data
    tag = "R4";
    do_load(3, 0);
    for (int i = 0; i < 64; i++) begin
      din = scr[i]; rd_beat = 1'b1; #1;
      chk(int'(dout), int'(orig[i]), "round trip");
      tick();
    end
    rd_beat = 1'b0;

    // R8 R9: mid-chunk load, beats during the seek are ignored
    tag = "R8";
    do_load(12, 37);
    busy_n = 0;
    tag = "R9";
    wr_beat = 1'b1;
    while (seek_busy && busy_n < 20) begin
      busy_n++; tick();
    end
    chk(busy_n, 5, "R8 seek length");
    tag = "R8";
    for (int i = 0; i < 12; i++) begin
      din = 8'(i); tick();
    end
    wr_beat = 1'b0;
    // read back column 37 alone after a fresh seek
    do_load(12, 37);
    while (seek_busy) tick();
    din = 8'h00; #1;
    chk(int'(dout), (ref_step(ref_step(ref_step(ref_step(ref_step(ref_seed((12 + 2) % 16))))))
        >> 8) & 8'hFF, "R8 mask at column 37");

    // R6: zero table entry replaced by default
    tag = "R6";
    do_load(4, 0);
    din = 8'h00; #1;
    chk(int'(dout), 8'hAC, "default seed mask");
    tick();

    // R10: bypass passes data and still advances
    tag = "R10";
    bypass = 1'b1; wr_beat = 1'b1;
    for (int i = 0; i < 20; i++) begin
      din = 8'(8'hA5 ^ i); tick();
    end
    bypass = 1'b0;
    for (int i = 0; i < 6; i++) begin
      din = 8'(i); tick();
    end
    wr_beat = 1'b0;

    // R11: idle cycles hold the mask
    tag = "R11";
    din = 8'h3C;
    for (int i = 0; i < 5; i++) tick();

    // R9: beat in the same cycle as a load is ignored
    tag = "R9";
    wr_beat = 1'b1;
    do_load(9, 16);
    wr_beat = 1'b0;
    din = 8'h00; #1;
    chk(int'(dout), (ref_seed((9 + 1) % 16) >> 8) & 8'hFF, "load-cycle beat ignored");
    tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule